// File: doc/BRIEF.md
# Pixel Merge Accumulator

This block holds a 64-bit merge register that gathers packed pixel colour or depth values from a stream of integer additions. Each merge add sums two 64-bit operands, returns the full sum, and folds the high-order bits of each pixel-sized slice of that sum into the register. Before the new bits go in, the register is shifted right by an amount that depends on the pixel size. Repeated adds therefore build up packed pixels without any extra instructions.

A separate operation reads the register out. It returns the first operand ORed with the register and clears the register in the same cycle. Rendering code uses it to collect the packed result and to start the next accumulation from zero. The adds are plain modular integer adds. The register is the only state in the block.

Top module: `pixel_merge_acc`

## Requirements
- R1: With `rst` high at a rising clock edge, the merge register becomes zero. A later OR-merge with `src1` = 0 then returns 0.
- R2: For `op` = 1 (pixel add) and `op` = 2 (depth add), `result` equals (`src1` + `src2`) mod 2^64 in the same cycle.
- R3: A pixel add with `pix_size` = 0 (8-bit pixels) shifts the register right by 8. It then replaces bits 15..8 of every 16-bit lane with the same bits of the sum.
- R4: A pixel add with `pix_size` = 1 (16-bit pixels) shifts the register right by 6. It then replaces bits 15..10 of every 16-bit lane with the same bits of the sum.
- R5: A pixel add with `pix_size` = 2 (32-bit pixels) shifts the register right by 8. It then replaces bits 31..24 of every 32-bit lane with the same bits of the sum.
- R6: A depth add (`op` = 2) shifts the register right by 16. It then replaces bits 31..16 of every 32-bit lane with the same bits of the sum. `pix_size` has no effect on it.
- R7: For `op` = 3 (OR-merge), `result` equals `src1` OR the register's current value, and the register is zero after the clock edge.
- R8: For `op` = 0 (idle), `result` is zero and the register keeps its value.
- R9: A pixel add with the reserved `pix_size` = 3 still returns the sum, but it leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | 0 idle, 1 pixel add, 2 depth add, 3 OR-merge |
| pix_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 reserved |
| src1 | input | 64 | First operand |
| src2 | input | 64 | Second operand |
| result | output | 64 | Sum, OR-merge value, or zero when idle |

## Verification
The bench builds the block with the default WIDTH of 64. That gives four 16-bit lanes and two 32-bit lanes, so it can observe field insertion in the upper lanes and carries that cross lane boundaries. Hand-computed sequences pin down the shift amounts and the insertion fields for each mode. A long run of random operations, compared on every clock against a behavioural model, covers mode switches between accumulations, reset during accumulation, and the reserved size code.

// File: rtl/pixel_merge_acc.sv
`timescale 1ns/1ps
module pixel_merge_acc #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op,
  input  logic [1:0]       pix_size,
  input  logic [WIDTH-1:0] src1,
  input  logic [WIDTH-1:0] src2,
  output logic [WIDTH-1:0] result
);
  localparam int LANES16 = WIDTH / 16;
  localparam int LANES32 = WIDTH / 32;
  localparam int SH_P8   = 8;
  localparam int SH_P16  = 6;
  localparam int SH_P32  = 8;
  localparam int SH_Z    = 16;

  logic [WIDTH-1:0] merge_q, merge_d, sum, ins_mask, shifted;
  logic [WIDTH-1:0] m_p8, m_p16, m_p32, m_z;

  for (genvar g = 0; g < LANES16; g++) begin : g_l16
    assign m_p8[g*16 +: 16]  = 16'hFF00;
    assign m_p16[g*16 +: 16] = 16'hFC00;
  end
  for (genvar g = 0; g < LANES32; g++) begin : g_l32
    assign m_p32[g*32 +: 32] = 32'hFF00_0000;
    assign m_z[g*32 +: 32]   = 32'hFFFF_0000;
  end

  assign sum = src1 + src2;

  always_comb begin
    ins_mask = '0;
    shifted  = merge_q;
    merge_d  = merge_q;
    unique case (op)
      2'd1: begin
        unique case (pix_size)
          2'd0: begin shifted = merge_q >> SH_P8;  ins_mask = m_p8;  end
          2'd1: begin shifted = merge_q >> SH_P16; ins_mask = m_p16; end
          2'd2: begin shifted = merge_q >> SH_P32; ins_mask = m_p32; end
          default: begin shifted = merge_q; ins_mask = '0; end
        endcase
        merge_d = (shifted & ~ins_mask) | (sum & ins_mask);
      end
      2'd2: begin
        shifted  = merge_q >> SH_Z;
        ins_mask = m_z;
        merge_d  = (shifted & ~ins_mask) | (sum & ins_mask);
      end
      2'd3:    merge_d = '0;
      default: merge_d = merge_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) merge_q <= '0;
    else     merge_q <= merge_d;
  end

  assign result = (op == 2'd3) ? (src1 | merge_q) :
                  (op == 2'd0) ? '0 : sum;
endmodule

// File: rtl/pixel_merge_acc_chk.sv
`timescale 1ns/1ps
module pixel_merge_acc_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       op,
  input logic [1:0]       pix_size,
  input logic [WIDTH-1:0] src1,
  input logic [WIDTH-1:0] src2,
  input logic [WIDTH-1:0] result,
  input logic [WIDTH-1:0] merge_q
);
  logic [WIDTH-1:0] s;
  assign s = src1 + src2;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> merge_q == '0);
  p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd1 || op == 2'd2) |-> result == s);
  p_p8_field_r3: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd1 && pix_size == 2'd0) |=>
      (merge_q[15:8] == $past(s[15:8]) && merge_q[7:0] == $past(merge_q[15:8])));
  p_p16_field_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd1 && pix_size == 2'd1) |=>
      (merge_q[15:10] == $past(s[15:10]) && merge_q[9:0] == $past(merge_q[15:6])));
  p_p32_field_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd1 && pix_size == 2'd2) |=>
      (merge_q[31:24] == $past(s[31:24]) && merge_q[23:0] == $past(merge_q[31:8])));
  p_depth_field_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd2) |=>
      (merge_q[31:16] == $past(s[31:16]) && merge_q[15:0] == $past(merge_q[31:16])));
  p_or_out_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd3) |-> result == (src1 | merge_q));
  p_or_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd3) |=> merge_q == '0);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd0) |=> $stable(merge_q));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd0) |-> result == '0);
  p_rsvd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 2'd1 && pix_size == 2'd3) |=> $stable(merge_q));
endmodule

bind pixel_merge_acc pixel_merge_acc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .op(op), .pix_size(pix_size),
  .src1(src1), .src2(src2), .result(result), .merge_q(merge_q)
);

// File: tb/pixel_merge_acc_bench.sv
`timescale 1ns/1ps
module pixel_merge_acc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op = 2'd0;
  logic [1:0]  pix_size = 2'd0;
  logic [63:0] src1 = '0, src2 = '0;
  logic [63:0] result;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [63:0] model = '0;

  always #2 clk = ~clk;

  pixel_merge_acc u_pixel_merge_acc (
    .clk(clk), .rst(rst), .op(op), .pix_size(pix_size),
    .src1(src1), .src2(src2), .result(result)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] o, logic [1:0] sz);
    if (o == 2'd0) return "R8";
    if (o == 2'd3) return "R7";
    if (o == 2'd2) return "R6";
    case (sz)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [63:0] next_model(logic [63:0] m, logic [1:0] o,
                                              logic [1:0] sz, logic [63:0] total);
    logic [63:0] n;
    int sh;
    n = m;
    if (o == 2'd3) return '0;
    if (o == 2'd0) return m;
    if (o == 2'd1 && sz == 2'd3) return m;
    sh = (o == 2'd2) ? 16 : (sz == 2'd1) ? 6 : 8;
    n = m >> sh;
    for (int i = 0; i < 64; i++) begin
      bit ld;
      if (o == 2'd2)       ld = (i % 32) >= 16;
      else if (sz == 2'd0) ld = (i % 16) >= 8;
      else if (sz == 2'd1) ld = (i % 16) >= 10;
      else                 ld = (i % 32) >= 24;
      if (ld) n[i] = total[i];
    end
    return n;
  endfunction

  task automatic step(logic [1:0] o, logic [1:0] sz, logic [63:0] a, logic [63:0] b);
    logic [63:0] total, exp;
    @(negedge clk);
    op = o; pix_size = sz; src1 = a; src2 = b;
    #1;
    total = a + b;
    exp = (o == 2'd0) ? 64'd0 : (o == 2'd3) ? (a | model) : total;
    if (o == 2'd1 || o == 2'd2) check("R2", result, exp);
    else check(tag_of(o, sz), result, exp);
    @(posedge clk);
    model = next_model(model, o, sz, total);
  endtask

  task automatic peek(string req, logic [63:0] exp);
    check(req, model, exp);
    step(2'd3, 2'd0, 64'd0, 64'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op = 2'd0;
    @(posedge clk);
    model = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    peek("R1", 64'd0);

    step(2'd1, 2'd0, 64'h1200, 64'h0034);
    step(2'd1, 2'd0, 64'h0000, 64'hAB00);
    peek("R3", 64'h0000_0000_0000_AB12);

    step(2'd1, 2'd1, 64'hFFFF, 64'h0);
    step(2'd1, 2'd1, 64'h0, 64'h0);
    peek("R4", 64'h0000_0000_0000_03F0);

    step(2'd1, 2'd2, 64'hFF00_0000_7700_0000, 64'h0100_0000_0000_0000);
    peek("R5", 64'h0000_0000_7700_0000);

    step(2'd2, 2'd3, 64'hABCD_0000, 64'h1234);
    step(2'd2, 2'd1, 64'h0, 64'h0);
    peek("R6", 64'h0000_0000_0000_ABCD);

    step(2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    check("R2", model, 64'h0);
    step(2'd1, 2'd0, 64'h5A5A_5A5A_5A5A_5A5A, 64'h0101_0101_0101_0101);
    step(2'd0, 2'd0, 64'hFFFF, 64'hFFFF);
    step(2'd1, 2'd3, 64'h1234_5678_9ABC_DEF0, 64'h1);
    peek("R9", 64'h5B00_5B00_5B00_5B00);

    step(2'd2, 2'd0, 64'h1111_2222_3333_4444, 64'h0);
    step(2'd3, 2'd0, 64'hF000_0000_0000_000F, 64'h0);
    peek("R7", 64'h0);

    step(2'd1, 2'd0, 64'hFF00, 64'h0);
    do_reset();
    peek("R1", 64'h0);

    for (int k = 0; k < 3000; k++) begin
      logic [1:0] o, sz;
      o  = 2'($urandom_range(0, 3));
      sz = 2'($urandom_range(0, 3));
      if (o == 2'd3 && $urandom_range(0, 3) != 0) o = 2'd1;
      if (k % 997 == 500) do_reset();
      step(o, sz, {$urandom, $urandom}, {$urandom, $urandom});
    end
    peek("R3", model);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule